// File: doc/BRIEF.md
# Two-Wire Configuration Register Target

This block is a target on a two-wire serial bus (I2C) that lets an external bus master read and write a small bank of byte-wide configuration registers. The bus clock and data lines are first passed through synchronizers running on a faster system clock. The block then finds bus conditions and SCL edges in that clock domain. It answers to one 7-bit device address. The upper five bits of that address are fixed, and the two low bits come from strap pins, so up to four copies can share one bus.

A master writes by sending the device address with the direction bit low, then a pointer byte, then any number of data bytes. Each data byte lands in the register the pointer selects, and the pointer then steps on, wrapping around the bank. To read, the master sets the pointer the same way, issues a repeated START, and addresses the device again with the direction bit high. Bytes come out from the pointer onward for as long as the master acknowledges them. The block only pulls the data line low (open-drain). It never stretches the clock.

The register contents drive parallel output pins continuously. The outputs are plain level signals with no valid/ready handshake: a value stays until a bus write replaces it, so a consumer never applies back-pressure and never needs to.

Top module: `i2c_cfg_target`

## Requirements
- R1: After a synchronous active-low reset, every register output is zero and `sda_pull` is low (SDA released).
- R2: An address byte whose upper seven bits equal binary 10110 followed by `addr_strap[1]`, `addr_strap[0]` is acknowledged: `sda_pull` is high during the high period of the ninth SCL pulse.
- R3: An address byte that does not match gets no acknowledge. SDA stays released for the rest of that transfer and no register changes, until the next START.
- R4: After a matching address with R/W low, the next byte loads the pointer (its low three bits select the register). Each later byte is written to the selected register, and every received byte is acknowledged.
- R5: After each written byte the pointer advances by one. Register 7 is followed by register 0, so a burst longer than the bank overwrites earlier registers in order.
- R6: A data byte counts as complete at the falling SCL edge that ends its eighth bit. A STOP or a repeated START before that point leaves every register unchanged.
- R7: A repeated START keeps the pointer. A following matching address with R/W high is acknowledged, and the selected register is then sent MSB first.
- R8: During a read, each byte the master acknowledges advances the pointer, with the same wrap from 7 to 0, and the next register is sent.
- R9: When the master does not acknowledge a read byte, the target releases SDA and sends nothing more until the next START.
- R10: `sda_pull` changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Synchronous reset, active low |
| scl_in | input | 1 | Bus clock line as seen on the pin |
| sda_in | input | 1 | Bus data line as seen on the pin |
| sda_pull | output | 1 | High pulls SDA low (open-drain enable) |
| addr_strap | input | 2 | Low two bits of the device address |
| cfg_q | output | 64 | Register contents; register k is bits 8k+7 down to 8k |

## Verification
The bench builds the block with its defaults: eight registers and two synchronizer stages. With eight registers, a nine-byte write burst and a three-byte read both cross the wrap from register 7 back to 0 in a short run. The strap pins are changed between transfers, so both a matching and a non-matching address can be tried on one instance. Bytes cut short by STOP and by repeated START are driven with fewer than eight bits, so the discard rule is tested on both kinds of interruption.

// File: rtl/i2c_cfg_pkg.sv
package i2c_cfg_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_PTR,
    ST_PTR_ACK,
    ST_WDATA,
    ST_WACK,
    ST_RLOAD,
    ST_RDATA,
    ST_RACK
  } tgt_state_e;
endpackage

// File: rtl/i2c_cfg_sync.sv
module i2c_cfg_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_ff;
  logic [STAGES-1:0] sda_ff;
  logic              scl_d;
  logic              sda_d;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[STAGES-2:0], scl_in};
      sda_ff <= {sda_ff[STAGES-2:0], sda_in};
      scl_d  <= scl_ff[STAGES-1];
      sda_d  <= sda_ff[STAGES-1];
    end
  end

  assign scl_s     = scl_ff[STAGES-1];
  assign sda_s     = sda_ff[STAGES-1];
  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  // data edge while clock stays high marks a bus condition
  assign start_det = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/i2c_cfg_regs.sv
module i2c_cfg_regs #(
  parameter int NUM_REGS = 8,
  parameter int DATA_W   = 8,
  localparam int IDX_W   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       we,
  input  logic [IDX_W-1:0]           widx,
  input  logic [DATA_W-1:0]          wdata,
  input  logic [IDX_W-1:0]           ridx,
  output logic [DATA_W-1:0]          rdata,
  output logic [NUM_REGS*DATA_W-1:0] q_flat
);
  logic [DATA_W-1:0] q_r [NUM_REGS];

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        q_r[i] <= '0;
      end else if (we && widx == IDX_W'(i)) begin
        q_r[i] <= wdata;
      end
    end
    assign q_flat[i*DATA_W +: DATA_W] = q_r[i];

    // R4: a write strobe for this entry lands on its output next cycle
    p_write_lands_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (we && widx == IDX_W'(i)) |=> (q_flat[i*DATA_W +: DATA_W] == $past(wdata)));
  end

  always_comb begin
    rdata = '0;
    for (int k = 0; k < NUM_REGS; k++) begin
      if (ridx == IDX_W'(k)) rdata = q_r[k];
    end
  end
endmodule

// File: rtl/i2c_cfg_target.sv
module i2c_cfg_target
  import i2c_cfg_pkg::*;
#(
  parameter int          NUM_REGS    = 8,
  parameter int          SYNC_STAGES = 2,
  parameter logic [4:0]  DEV_ID_HI   = 5'b10110,
  localparam int         IDX_W       = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1,
  localparam int         OUT_W       = NUM_REGS * BYTE_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_in,
  input  logic             sda_in,
  output logic             sda_pull,
  input  logic [1:0]       addr_strap,
  output logic [OUT_W-1:0] cfg_q
);
  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;

  i2c_cfg_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  tgt_state_e        state;
  logic [3:0]        bit_cnt;
  logic [BYTE_W-1:0] rx_sh;
  logic [BYTE_W-1:0] tx_sh;
  logic              rw_bit;
  logic              mst_ack;
  logic [IDX_W-1:0]  ptr;
  logic              wr_en;
  logic [BYTE_W-1:0] rd_data;
  logic              byte_done;

  function automatic logic [IDX_W-1:0] ptr_step(input logic [IDX_W-1:0] p);
    return (p == IDX_W'(NUM_REGS - 1)) ? '0 : p + 1'b1;
  endfunction

  assign byte_done = scl_fall && (bit_cnt == 4'd8) && !start_det && !stop_det;
  assign wr_en     = (state == ST_WDATA) && byte_done;

  i2c_cfg_regs #(.NUM_REGS(NUM_REGS), .DATA_W(BYTE_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(wr_en), .widx(ptr), .wdata(rx_sh),
    .ridx(ptr), .rdata(rd_data), .q_flat(cfg_q)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      bit_cnt  <= '0;
      rx_sh    <= '0;
      tx_sh    <= '0;
      rw_bit   <= 1'b0;
      mst_ack  <= 1'b0;
      ptr      <= '0;
      sda_pull <= 1'b0;
    end else if (start_det) begin
      state    <= ST_ADDR;
      bit_cnt  <= '0;
      sda_pull <= 1'b0;
    end else if (stop_det) begin
      state    <= ST_IDLE;
      bit_cnt  <= '0;
      sda_pull <= 1'b0;
    end else begin
      unique case (state)
        ST_ADDR, ST_PTR, ST_WDATA: begin
          if (scl_rise) begin
            rx_sh   <= {rx_sh[BYTE_W-2:0], sda_s};
            bit_cnt <= bit_cnt + 1'b1;
          end else if (byte_done) begin
            bit_cnt <= '0;
            if (state == ST_ADDR) begin
              if (rx_sh[7:1] == {DEV_ID_HI, addr_strap}) begin
                rw_bit   <= rx_sh[0];
                sda_pull <= 1'b1;
                state    <= ST_ADDR_ACK;
              end else begin
                state <= ST_IDLE;
              end
            end else if (state == ST_PTR) begin
              ptr      <= rx_sh[IDX_W-1:0];
              sda_pull <= 1'b1;
              state    <= ST_PTR_ACK;
            end else begin
              ptr      <= ptr_step(ptr);
              sda_pull <= 1'b1;
              state    <= ST_WACK;
            end
          end
        end
        ST_ADDR_ACK: begin
          if (scl_fall) begin
            sda_pull <= 1'b0;
            state    <= rw_bit ? ST_RLOAD : ST_PTR;
          end
        end
        ST_PTR_ACK, ST_WACK: begin
          if (scl_fall) begin
            sda_pull <= 1'b0;
            state    <= ST_WDATA;
          end
        end
        ST_RLOAD: begin
          tx_sh    <= rd_data;
          sda_pull <= ~rd_data[BYTE_W-1];
          bit_cnt  <= '0;
          state    <= ST_RDATA;
        end
        ST_RDATA: begin
          if (scl_fall) begin
            if (bit_cnt == 4'd7) begin
              sda_pull <= 1'b0;
              bit_cnt  <= '0;
              state    <= ST_RACK;
            end else begin
              tx_sh    <= {tx_sh[BYTE_W-2:0], 1'b0};
              sda_pull <= ~tx_sh[BYTE_W-2];
              bit_cnt  <= bit_cnt + 1'b1;
            end
          end
        end
        ST_RACK: begin
          if (scl_rise) begin
            mst_ack <= ~sda_s;
          end else if (scl_fall) begin
            if (mst_ack) begin
              ptr   <= ptr_step(ptr);
              state <= ST_RLOAD;
            end else begin
              state <= ST_IDLE;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R10: the data line is only moved while the clock is low
  p_sda_scl_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_pull != $past(sda_pull)) |-> (!scl_s || $past(start_det) || $past(stop_det)));

  // R9 and R3: an idle target never holds the data line
  p_idle_released_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE) |-> !sda_pull);

  // R2: every START restarts address reception
  p_start_to_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> (state == ST_ADDR));

  // R6: after a bus condition no write strobe follows
  p_cut_no_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (start_det || stop_det) |=> !wr_en);

  // R5: the pointer steps with wrap after each stored byte
  p_ptr_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (ptr == (($past(ptr) == IDX_W'(NUM_REGS - 1)) ? '0 : $past(ptr) + 1'b1)));
endmodule

// File: tb/sim_i2c_cfg_target.sv
module sim_i2c_cfg_target;
  localparam time CLK_PERIOD = 10ns;
  localparam int  Q          = 8;
  localparam int  NREG       = 8;

  typedef struct {
    logic [7:0] v;
    string      req;
  } sb_item_t;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              scl_m = 1'b1;
  logic              sda_m = 1'b1;
  logic [1:0]        strap = 2'b10;
  logic              sda_pull;
  logic [NREG*8-1:0] cfg_q;
  wire               sda_line = sda_m & ~sda_pull;

  int total = 0;
  int bad = 0;
  int r10_viol = 0;
  bit done = 1'b0;
  logic [7:0] mdl [NREG];
  sb_item_t exp_q[$];
  sb_item_t act_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_cfg_target u0 (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_line),
    .sda_pull(sda_pull), .addr_strap(strap), .cfg_q(cfg_q)
  );

  // R10 watcher: pull changes must not fall into a high clock phase
  always @(sda_pull) if (rst_n && scl_m) r10_viol++;

  // scoreboard monitor
  initial begin
    forever begin
      wait (act_q.size() > 0);
      begin
        sb_item_t a, e;
        a = act_q.pop_front();
        total++;
        if (exp_q.size() == 0) begin
          bad++;
          $display("FAIL %s: actual %h expected <none>", a.req, a.v);
        end else begin
          e = exp_q.pop_front();
          if (a.v !== e.v) begin
            bad++;
            $display("FAIL %s: actual %h expected %h", e.req, a.v, e.v);
          end
        end
      end
    end
  end

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] expv);
    total++;
    if (act !== expv) begin
      bad++;
      $display("FAIL %s: actual %h expected %h", req, act, expv);
    end
  endtask

  function automatic logic [NREG*8-1:0] mdl_flat();
    logic [NREG*8-1:0] f;
    for (int k = 0; k < NREG; k++) f[k*8 +: 8] = mdl[k];
    return f;
  endfunction

  task automatic expect_item(input logic [7:0] v, input string req);
    sb_item_t it;
    it.v = v; it.req = req;
    exp_q.push_back(it);
  endtask

  task automatic got_item(input logic [7:0] v, input string req);
    sb_item_t it;
    it.v = v; it.req = req;
    act_q.push_back(it);
  endtask

  task automatic wq();
    #(Q * CLK_PERIOD);
  endtask

  task automatic clk_bit(input logic b, output logic s);
    sda_m = b; wq();
    scl_m = 1'b1; wq();
    s = sda_line; wq();
    scl_m = 1'b0; wq();
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wq();
    scl_m = 1'b1; wq();
    sda_m = 1'b0; wq();
    scl_m = 1'b0; wq();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wq();
    scl_m = 1'b1; wq();
    sda_m = 1'b1; wq();
  endtask

  // sends a byte, records the ack bit (0 = acknowledged)
  task automatic send_byte(input logic [7:0] b, input string req);
    logic s;
    for (int i = 7; i >= 0; i--) clk_bit(b[i], s);
    clk_bit(1'b1, s);
    got_item({7'b0, s}, req);
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    logic s;
    for (int i = 0; i < n; i++) clk_bit(b[7-i], s);
  endtask

  task automatic read_byte(input logic ack, input string req);
    logic s;
    logic [7:0] r;
    for (int i = 7; i >= 0; i--) begin
      clk_bit(1'b1, s);
      r[i] = s;
    end
    clk_bit(~ack, s);
    got_item(r, req);
  endtask

  task automatic drain();
    wait (act_q.size() == 0);
    #(CLK_PERIOD);
  endtask

  task automatic report();
    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(200000 * CLK_PERIOD);
    total++;
    bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    for (int k = 0; k < NREG; k++) mdl[k] = 8'h00;
    #2ns;
    repeat (4) #(CLK_PERIOD);
    rst_n = 1'b1;
    wq();
    check("R1 reset outputs", {{(64-NREG*8){1'b0}}, cfg_q}, 64'h0);
    check("R1 reset sda", {63'b0, sda_pull}, 64'h0);

    // single write, strap = 10 -> address byte 0xB4
    strap = 2'b10;
    bus_start();
    expect_item(8'h00, "R2 address ack"); send_byte(8'hB4, "R2");
    expect_item(8'h00, "R4 pointer ack"); send_byte(8'h03, "R4");
    expect_item(8'h00, "R4 data ack");    send_byte(8'hA5, "R4");
    mdl[3] = 8'hA5;
    bus_stop();
    drain();
    check("R4 single write", cfg_q, mdl_flat());

    // wrong address: strap 00 would be 0xB0
    bus_start();
    expect_item(8'h01, "R3 no address ack"); send_byte(8'hB0, "R3");
    expect_item(8'h01, "R3 no ack later");   send_byte(8'h03, "R3");
    expect_item(8'h01, "R3 no ack later");   send_byte(8'h5A, "R3");
    bus_stop();
    drain();
    check("R3 regs untouched", cfg_q, mdl_flat());

    // strap 01 -> 0xB2, burst of nine from register 6
    strap = 2'b01;
    bus_start();
    expect_item(8'h00, "R2 strap 01 ack"); send_byte(8'hB2, "R2");
    expect_item(8'h00, "R5 pointer ack");  send_byte(8'h06, "R5");
    for (int j = 0; j < 9; j++) begin
      expect_item(8'h00, "R5 burst ack");
      send_byte(8'h10 + 8'(j), "R5");
      mdl[(6 + j) % NREG] = 8'h10 + 8'(j);
    end
    bus_stop();
    drain();
    check("R5 wrap overwrite", cfg_q, mdl_flat());

    // cut by STOP mid byte
    strap = 2'b10;
    bus_start();
    expect_item(8'h00, "R6 addr ack"); send_byte(8'hB4, "R6");
    expect_item(8'h00, "R6 ptr ack");  send_byte(8'h01, "R6");
    send_bits(8'hAF, 4);
    bus_stop();
    drain();
    check("R6 stop discards", cfg_q, mdl_flat());

    // full byte then cut by repeated START after seven bits
    bus_start();
    expect_item(8'h00, "R6 addr ack"); send_byte(8'hB4, "R6");
    expect_item(8'h00, "R6 ptr ack");  send_byte(8'h02, "R6");
    expect_item(8'h00, "R6 data ack"); send_byte(8'h77, "R6");
    mdl[2] = 8'h77;
    send_bits(8'hC3, 7);
    bus_start();
    bus_stop();
    drain();
    check("R6 rstart discards", cfg_q, mdl_flat());

    // random then sequential read from 7 with wrap, ending in NACK
    bus_start();
    expect_item(8'h00, "R7 addr ack"); send_byte(8'hB4, "R7");
    expect_item(8'h00, "R7 ptr ack");  send_byte(8'h07, "R7");
    bus_start();
    expect_item(8'h00, "R7 read addr ack"); send_byte(8'hB5, "R7");
    expect_item(mdl[7], "R7 first byte");   read_byte(1'b1, "R7");
    expect_item(mdl[0], "R8 wrap byte");    read_byte(1'b1, "R8");
    expect_item(mdl[1], "R8 next byte");    read_byte(1'b0, "R8");
    expect_item(8'hFF, "R9 released after nack"); read_byte(1'b0, "R9");
    bus_stop();
    drain();
    check("R9 idle release", {63'b0, sda_pull}, 64'h0);
    check("R10 pull moves in low phase", 64'(r10_viol), 64'h0);
    check("R1 registers hold", cfg_q, mdl_flat());
    report();
  end
endmodule